// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer with Address-Width Discovery

This block reads 16-bit words from a three-wire serial EEPROM by driving a 16-bit control word whose low bits act as the serial clock, chip select and data-to-device lines. It takes its input from the device's data-out line. A read is launched with a single-cycle start pulse. The sequencer raises chip select, sends a three-bit read command, shifts the word address out MSB first and then clocks in sixteen data bits MSB first. It ends by clearing every control bit.

The address width of the attached device is not a parameter. On the first access after reset the sequencer keeps sending zero address bits until the device answers with its dummy zero. The number of bits sent up to that point is stored as the width and is reused on every later access. Because that first pass only sizes the device, the sequencer repeats the read before it reports data. A dump mode reads every word of the device, from address 0 to 2^width - 1. It keeps a 16-bit wrapping sum of those words and flags any total other than 0xBABA. A clock divider stretches every serial clock phase to a programmable number of system clock cycles.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset the control word is zero, busy and done are low, the width is not valid, and both error flags are clear.
- R2: Only control bits 0 (serial clock), 1 (chip select) and 2 (data to device) are ever driven. Bits 15 to 3 stay zero, and the serial clock is high only while chip select is high.
- R3: Each device access sends the preamble 1, 1, 0 MSB first, which is the start bit followed by read opcode binary 10. The word address follows, MSB first.
- R4: The data-to-device bit is set up while the serial clock is low and does not change while the clock is high.
- R5: When the width is not yet known, the first access sends zero address bits until the device output reads 0 after a bit. The number of bits sent is then stored as the width, the width is marked valid, and the read is repeated so that it returns real data.
- R6: The sixteen data bits are sampled during the clock-high phase and assembled MSB first into the read data output.
- R7: After the sixteenth data bit, all control bits are cleared for one phase before any further access, and they stay zero while the block is idle.
- R8: In dump mode, all 2^width words are read starting from address 0. The running sum is the 16-bit wrapping total of those words, and the checksum-error flag is set when that total differs from 0xBABA and cleared otherwise.
- R9: If no dummy zero appears within 8 address bits, the width is recorded as 8 and the size-error flag is set.
- R10: Each serial clock high phase and each low phase lasts at least DIV system clock cycles. With a known width W, a single read keeps busy high for exactly (2 + 3*(19+W))*DIV cycles.
- R11: Busy rises in the cycle after an accepted start. Done is a single-cycle pulse at the end of the operation. A start that arrives while busy is ignored.
- R12: Once the width is valid, later reads access the device exactly once each, with no further sizing pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| dump_all | input | 1 | 1 = read the whole device and check its sum, 0 = read one word |
| word_addr | input | 8 | Word address for a single read |
| ser_in | input | 1 | Data line from the EEPROM |
| ctl_word | output | 16 | Control word: bit 0 serial clock, bit 1 chip select, bit 2 data to device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| addr_width | output | 4 | Discovered address width |
| width_valid | output | 1 | Address width has been discovered |
| size_err | output | 1 | No dummy zero was seen within 8 bits |
| sum_total | output | 16 | Running sum of the last dump |
| sum_err | output | 1 | Dump total differs from 0xBABA |

## Verification
The bench drives a behavioural EEPROM whose address width can be set to 6, to 4, or to a missing device that never pulls its output low. A sequencer that counted the dummy zero as an address bit would store a width that is one too large. A sequencer that returned data straight from the sizing pass would deliver the wrong word on the very first read. The model counts device accesses, so a design that sized the device again on every read is caught. A start pulsed in the middle of a read must leave the first address in effect. A single corrupted word must turn the dump checksum into an error. The exact busy length at DIV=2 exposes a phase that is too short or an extra idle phase.

// File: rtl/eepr_pkg.sv
package eepr_pkg;

    localparam int SK_BIT = 0;
    localparam int CS_BIT = 1;
    localparam int DI_BIT = 2;

    localparam logic [15:0] DUMP_GOLD = 16'hBABA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSON,
        ST_SET,
        ST_HIGH,
        ST_LOW,
        ST_CSOFF
    } seq_st_e;

    typedef enum logic [1:0] {
        SEG_CMD,
        SEG_ADR,
        SEG_DAT
    } seg_e;

    typedef struct packed {
        logic sk;
        logic cs;
        logic di;
    } pins_t;

    // start bit then read opcode, sent in index order 0..2
    function automatic logic cmd_bit(input logic [1:0] idx);
        return (idx != 2'd2);
    endfunction

endpackage

// File: rtl/eepr_tick.sv
module eepr_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/eepr_sum.sv
module eepr_sum #(
    parameter int          DW   = 16,
    parameter logic [15:0] GOLD = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          add,
    input  logic          fin,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] sum,
    output logic          err
);
    logic [DW-1:0] nxt;
    assign nxt = sum + word;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
            err <= 1'b0;
        end else if (add) begin
            sum <= nxt;
            if (fin) err <= (nxt != DW'(GOLD));
        end
    end
endmodule

// File: rtl/eepr_seq.sv
module eepr_seq
    import eepr_pkg::*;
#(
    parameter int MAX_AW = 8,
    parameter int DW     = 16,
    parameter int WW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic              dump_all,
    input  logic [MAX_AW-1:0] word_addr,
    input  logic              ser_in,
    output pins_t             pins,
    output logic              launch,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rd_data,
    output logic [WW-1:0]     width,
    output logic              wvalid,
    output logic              size_err,
    output logic              word_add,
    output logic              dump_fin,
    output logic [DW-1:0]     word_val
);
    localparam int IW = $clog2(DW);

    seq_st_e           state;
    seg_e              seg;
    logic [IW-1:0]     idx;
    logic [MAX_AW-1:0] cur_addr, req_addr, addr_sh, last_addr;
    logic [DW-1:0]     shreg;
    logic              sizing, dump_mode, cur_bit;
    logic [WW-1:0]     nbits;

    assign nbits     = wvalid ? width : WW'(MAX_AW);
    assign last_addr = MAX_AW'((1 << int'(width)) - 1);
    assign busy      = (state != ST_IDLE);
    assign launch    = start && (state == ST_IDLE);
    assign word_add  = (state == ST_CSOFF) && tick && !sizing && dump_mode;
    assign dump_fin  = word_add && (cur_addr == last_addr);
    assign word_val  = shreg;

    always_comb begin
        unique case (seg)
            SEG_CMD: cur_bit = cmd_bit(idx[1:0]);
            SEG_ADR: cur_bit = addr_sh[MAX_AW-1];
            default: cur_bit = 1'b0;
        endcase
    end

    always_comb begin
        pins = '0;
        unique case (state)
            ST_CSON: pins.cs = 1'b1;
            ST_SET:  begin pins.cs = 1'b1; pins.di = cur_bit; end
            ST_HIGH: begin pins.cs = 1'b1; pins.sk = 1'b1; pins.di = cur_bit; end
            ST_LOW:  begin pins.cs = 1'b1; pins.di = cur_bit; end
            default: pins = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            seg       <= SEG_CMD;
            idx       <= '0;
            cur_addr  <= '0;
            req_addr  <= '0;
            addr_sh   <= '0;
            shreg     <= '0;
            sizing    <= 1'b0;
            dump_mode <= 1'b0;
            rd_data   <= '0;
            width     <= '0;
            wvalid    <= 1'b0;
            size_err  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    dump_mode <= dump_all;
                    sizing    <= !wvalid;
                    req_addr  <= word_addr;
                    cur_addr  <= (dump_all || !wvalid) ? '0 : word_addr;
                    state     <= ST_CSON;
                end
                ST_CSON: if (tick) begin
                    seg     <= SEG_CMD;
                    idx     <= '0;
                    addr_sh <= cur_addr << (MAX_AW - int'(nbits));
                    state   <= ST_SET;
                end
                ST_SET: if (tick) state <= ST_HIGH;
                ST_HIGH: if (tick) begin
                    if (seg == SEG_DAT) shreg <= {shreg[DW-2:0], ser_in};
                    state <= ST_LOW;
                end
                ST_LOW: if (tick) begin
                    state <= ST_SET;
                    unique case (seg)
                        SEG_CMD: begin
                            if (idx == IW'(2)) begin seg <= SEG_ADR; idx <= '0; end
                            else idx <= idx + 1'b1;
                        end
                        SEG_ADR: begin
                            addr_sh <= addr_sh << 1;
                            idx     <= idx + 1'b1;
                            if (!wvalid) begin
                                if (!ser_in) begin
                                    width  <= WW'(int'(idx) + 1);
                                    wvalid <= 1'b1;
                                    seg    <= SEG_DAT;
                                    idx    <= '0;
                                end else if (int'(idx) + 1 == MAX_AW) begin
                                    width    <= WW'(MAX_AW);
                                    wvalid   <= 1'b1;
                                    size_err <= 1'b1;
                                    seg      <= SEG_DAT;
                                    idx      <= '0;
                                end
                            end else if (!ser_in || (int'(idx) + 1 == int'(width))) begin
                                seg <= SEG_DAT;
                                idx <= '0;
                            end
                        end
                        default: begin
                            if (idx == IW'(DW - 1)) state <= ST_CSOFF;
                            else idx <= idx + 1'b1;
                        end
                    endcase
                end
                ST_CSOFF: if (tick) begin
                    if (sizing) begin
                        sizing   <= 1'b0;
                        cur_addr <= dump_mode ? '0 : req_addr;
                        state    <= ST_CSON;
                    end else begin
                        rd_data <= shreg;
                        if (dump_mode && (cur_addr != last_addr)) begin
                            cur_addr <= cur_addr + 1'b1;
                            state    <= ST_CSON;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
    import eepr_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int MAX_AW = 8,
    parameter int DW     = 16,
    parameter int CSR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dump_all,
    input  logic [MAX_AW-1:0] word_addr,
    input  logic              ser_in,
    output logic [CSR_W-1:0]  ctl_word,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rd_data,
    output logic [3:0]        addr_width,
    output logic              width_valid,
    output logic              size_err,
    output logic [DW-1:0]     sum_total,
    output logic              sum_err
);
    localparam int WW = 4;

    pins_t         pins;
    logic          tick, launch, word_add, dump_fin;
    logic [DW-1:0] word_val;

    eepr_tick #(.DIV(DIV)) tick_i (
        .clk(clk), .rst(rst), .clr(launch), .run(busy), .tick(tick)
    );

    eepr_seq #(.MAX_AW(MAX_AW), .DW(DW), .WW(WW)) seq_i (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .dump_all(dump_all),
        .word_addr(word_addr), .ser_in(ser_in), .pins(pins), .launch(launch),
        .busy(busy), .done(done), .rd_data(rd_data), .width(addr_width),
        .wvalid(width_valid), .size_err(size_err), .word_add(word_add),
        .dump_fin(dump_fin), .word_val(word_val)
    );

    eepr_sum #(.DW(DW), .GOLD(DUMP_GOLD)) sum_i (
        .clk(clk), .rst(rst), .clr(launch && dump_all), .add(word_add),
        .fin(dump_fin), .word(word_val), .sum(sum_total), .err(sum_err)
    );

    always_comb begin
        ctl_word         = '0;
        ctl_word[SK_BIT] = pins.sk;
        ctl_word[CS_BIT] = pins.cs;
        ctl_word[DI_BIT] = pins.di;
    end
endmodule

// File: rtl/eepr_chk.sv
module eepr_chk #(
    parameter int DIV = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [15:0] ctl_word,
    input logic        busy,
    input logic        done,
    input logic [3:0]  addr_width,
    input logic        width_valid
);
    localparam int RW = $clog2(DIV + 2);

    logic          sk_prev;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_prev <= 1'b0;
            run_len <= '0;
        end else begin
            sk_prev <= ctl_word[0];
            if (ctl_word[0] != sk_prev) run_len <= RW'(1);
            else if (int'(run_len) < DIV) run_len <= run_len + 1'b1;
        end
    end

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_word[15:3] == 13'd0);
    p_sk_needs_cs_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_word[0] |-> ctl_word[1]);
    p_di_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_word[0] |-> $stable(ctl_word[2]));
    p_phase_len_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[0] != sk_prev) |-> (int'(run_len) >= DIV));
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ctl_word == 16'd0));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_rise_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    p_width_range_r5: assert property (@(posedge clk) disable iff (rst)
        width_valid |-> (addr_width >= 4'd1 && addr_width <= 4'd8));
    p_width_keep_r12: assert property (@(posedge clk) disable iff (rst)
        $past(width_valid) |-> (width_valid && $stable(addr_width)));
endmodule

bind mw_eeprom_reader eepr_chk #(.DIV(DIV)) chk_i (
    .clk(clk), .rst(rst), .start(start), .ctl_word(ctl_word), .busy(busy),
    .done(done), .addr_width(addr_width), .width_valid(width_valid)
);

// File: tb/mw_eeprom_reader_tb.sv
module mw_eeprom_reader_tb_top;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dump_all = 1'b0;
    logic [7:0]  word_addr = 8'd0;
    logic        ser_in;
    logic [15:0] ctl_word;
    logic        busy, done, width_valid, size_err, sum_err;
    logic [15:0] rd_data, sum_total;
    logic [3:0]  addr_width;

    int n_chk = 0;
    int n_bad = 0;
    int viol  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mw_eeprom_reader #(.DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .start(start), .dump_all(dump_all),
        .word_addr(word_addr), .ser_in(ser_in), .ctl_word(ctl_word),
        .busy(busy), .done(done), .rd_data(rd_data), .addr_width(addr_width),
        .width_valid(width_valid), .size_err(size_err), .sum_total(sum_total),
        .sum_err(sum_err)
    );

    // behavioural EEPROM
    logic [15:0] mem [0:255];
    int          maw = 6;
    int          mst = 0;
    int          mcnt = 0;
    logic [1:0]  mop = 2'b00;
    logic [7:0]  madr = 8'd0;
    logic [15:0] mword = 16'd0;
    logic        mdo = 1'b1;
    int          m_reads = 0;
    int          m_badop = 0;
    logic [7:0]  m_last = 8'd0;

    wire sk = ctl_word[0];
    wire cs = ctl_word[1];
    wire di = ctl_word[2];
    assign ser_in = mdo;

    always @(posedge sk or negedge cs) begin
        if (!cs) begin
            mst = 0; mcnt = 0; mdo = 1'b1;
        end else begin
            case (mst)
                0: if (di) begin mst = 1; mcnt = 0; mop = 2'b00; end
                1: begin
                    mop = {mop[0], di};
                    mcnt++;
                    if (mcnt == 2) begin
                        if (mop != 2'b10) m_badop++;
                        mst = 2; mcnt = 0; madr = 8'd0;
                    end
                end
                2: if (maw != 0) begin
                    madr = {madr[6:0], di};
                    mcnt++;
                    if (mcnt == maw) begin
                        mdo = 1'b0; mst = 3; mcnt = 0;
                        mword = mem[madr]; m_last = madr; m_reads++;
                    end
                end
                default: if (mcnt < 16) begin
                    mdo = mword[15 - mcnt];
                    mcnt++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && ((ctl_word[15:3] != 13'd0) || (sk && !cs))) viol++;
    end

    function automatic logic [15:0] pattern(input int i);
        return 16'((i * 16'h0913) ^ 16'h5A3C);
    endfunction

    task automatic fill(input int aw);
        logic [15:0] s;
        int n;
        s = 16'd0;
        n = 1 << aw;
        for (int i = 0; i < 256; i++) mem[i] = pattern(i);
        if (aw != 0) begin
            for (int i = 0; i < n - 1; i++) s = s + mem[i];
            mem[n-1] = 16'hBABA - s;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input int aw);
        maw = aw;
        fill(aw);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_op(input logic [7:0] a, input bit dmp, input int mid_start,
                          output int bcnt);
        int guard;
        @(negedge clk);
        start = 1'b1; word_addr = a; dump_all = dmp;
        @(negedge clk);
        start = 1'b0;
        bcnt = 0;
        guard = 0;
        while (!done && guard < 60000) begin
            if (busy) bcnt++;
            guard++;
            if (guard == mid_start) begin
                start = 1'b1; word_addr = a ^ 8'h11; dump_all = 1'b0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(done, "R11 done seen", int'(done), 1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(6);
        check(ctl_word == 16'd0, "R1 ctl", ctl_word, 0);
        check(!busy && !done, "R1 busy/done", {busy, done}, 0);
        check(!width_valid, "R1 width_valid", width_valid, 0);
        check(!size_err && !sum_err, "R1 errors", {size_err, sum_err}, 0);
    endtask

    task automatic t_first_read();
        int b, r0;
        r0 = m_reads;
        run_op(8'd5, 1'b0, 0, b);
        check(width_valid && addr_width == 4'd6, "R5 width", addr_width, 6);
        check(rd_data == mem[5], "R5 R6 data after sizing", rd_data, mem[5]);
        check(m_reads - r0 == 2, "R5 sizing plus real access", m_reads - r0, 2);
        check(m_last == 8'd5 && m_badop == 0, "R3 addr/opcode", m_last, 5);
        check(!size_err, "R9 no size error", size_err, 0);
    endtask

    task automatic t_known_read();
        int b, r0;
        r0 = m_reads;
        run_op(8'd63, 1'b0, 0, b);
        check(rd_data == mem[63], "R6 data", rd_data, mem[63]);
        check(m_reads - r0 == 1, "R12 single access", m_reads - r0, 1);
        check(b == (2 + 3 * (19 + 6)) * DIV, "R10 busy length", b, (2 + 3 * 25) * DIV);
        check(ctl_word == 16'd0, "R7 ctl cleared", ctl_word, 0);
    endtask

    task automatic t_start_while_busy();
        int b, r0;
        r0 = m_reads;
        run_op(8'd42, 1'b0, 20, b);
        check(rd_data == mem[42], "R11 ignored start data", rd_data, mem[42]);
        check(m_reads - r0 == 1 && m_last == 8'd42, "R11 one access", m_reads - r0, 1);
        repeat (5) @(negedge clk);
        check(!busy, "R11 no queued start", busy, 0);
    endtask

    task automatic t_dump(input bit corrupt, input int aw);
        int b, r0;
        if (corrupt) mem[3] = mem[3] ^ 16'h0001;
        r0 = m_reads;
        run_op(8'd0, 1'b1, 0, b);
        check(m_reads - r0 == (1 << aw), "R8 dump access count", m_reads - r0, 1 << aw);
        if (corrupt) begin
            check(sum_err && sum_total != 16'hBABA, "R8 corrupt dump flagged", sum_total, 16'hBABA);
        end else begin
            check(!sum_err && sum_total == 16'hBABA, "R8 dump sum", sum_total, 16'hBABA);
            check(rd_data == mem[(1 << aw) - 1], "R8 last word", rd_data, mem[(1 << aw) - 1]);
        end
    endtask

    task automatic t_width4();
        int b;
        do_reset(4);
        run_op(8'd9, 1'b0, 0, b);
        check(addr_width == 4'd4 && width_valid, "R5 width 4", addr_width, 4);
        check(rd_data == mem[9], "R6 data width 4", rd_data, mem[9]);
        t_dump(1'b0, 4);
    endtask

    task automatic t_no_device();
        int b;
        do_reset(0);
        run_op(8'd3, 1'b0, 0, b);
        check(addr_width == 4'd8 && width_valid, "R9 width 8", addr_width, 8);
        check(size_err, "R9 size error", size_err, 1);
        check(rd_data == 16'hFFFF, "R9 data all ones", rd_data, 16'hFFFF);
    endtask

    initial begin
        t_reset();
        t_first_read();
        t_known_read();
        t_start_while_busy();
        t_dump(1'b0, 6);
        t_dump(1'b1, 6);
        t_width4();
        t_no_device();
        check(viol == 0, "R2 R4 control bit rules", viol, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule